// File: doc/BRIEF.md
# Master-side loop transceiver signaling front end

This block is the control and signaling register stage that sits between a shared line-card controller bus and the burst modem of a master-side digital loop transceiver. It registers the power, loopback, signaling and insert-enable inputs while the bus-share enable is high. When that enable is low it holds them and floats its outputs, so that several units can hang on one controller bus. Each tri-state output is modelled as a data value plus an output-enable.

A system frame sync passes through a synchronizer and an edge detector. The resulting one-cycle pulse paces burst starts, the capture of signaling bits for transmission and the update of the received signaling bits and valid flag. After power-up the block waits for a run of frame-sync edges, or for the end of an incoming burst, before it starts bursts. While powered down it sends nothing. The demodulator keeps running in that state, and its results reach the outputs as soon as each burst is decoded. A loopback select is produced for the modem.

Top module: `sigfe_top`

## Requirements
- R1: While `bus_en_i` is high, every clock edge registers `run_i`, `lpbk_n_i`, `ins_en_i` and `sig_in_i`. While it is low, these registered values keep their last state, whatever those inputs do.
- R2: `sig_out_oe_o` and `valid_oe_o` equal the value `bus_en_i` had at the previous clock edge. Both are 0 in reset.
- R3: When a frame-sync rise is detected while the registered run bit is 1, `tx_sig_o` takes the registered signaling bits at the next edge. At all other times `tx_sig_o` holds.
- R4: A frame-sync rise is detected as a one-cycle pulse. `tx_start_o` goes high two clock edges after the edge that first samples `fsync_i` high, and it stays high for exactly one cycle.
- R5: While running, `sig_out_o` and `valid_o` change only at the edge that follows a detected frame-sync rise. They then take the results of the most recently completed demodulation.
- R6: While powered down (registered run bit 0), `sig_out_o` and `valid_o` take the new burst's results at the edge where `demod_done_i` is high.
- R7: The valid flag of a burst is 1 exactly when `sync_ok_i` is 1 and `bit_err_i` is 0 at `demod_done_i`.
- R8: After the run bit turns 1, bursts are armed by the third detected frame-sync rise (parameter `WAIT_EDGES` = 3), or earlier by a `demod_done_i` pulse. Once armed, every following detected rise gives a `tx_start_o` pulse. The rise that arms the block does not start a burst.
- R9: While the run bit is 0, `tx_start_o` stays 0 and the wait count is cleared. A later power-up therefore waits the full count again.
- R10: `loopback_o` is 1 exactly when the registered run bit is 1 and the registered `lpbk_n_i` is 0.
- R11: `ins_en_o` is the registered insert-enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock (2.048 MHz class) |
| rst_n | input | 1 | asynchronous active-low reset |
| run_i | input | 1 | 1 = powered up, 0 = power-down |
| lpbk_n_i | input | 1 | loopback request, active low |
| ins_en_i | input | 1 | signal insert enable |
| sig_in_i | input | 2 | signaling bits to send to the far end |
| fsync_i | input | 1 | system frame sync, asynchronous |
| bus_en_i | input | 1 | bus-share enable: 1 = sample and drive, 0 = hold and float |
| demod_done_i | input | 1 | receiver finished a burst (one-cycle pulse) |
| sync_ok_i | input | 1 | receiver found correct sync in the burst |
| bit_err_i | input | 1 | receiver detected a bit error in the burst |
| rx_sig_i | input | 2 | signaling bits decoded from the burst |
| sig_out_o | output | 2 | received signaling bits (data) |
| sig_out_oe_o | output | 1 | drive enable for sig_out_o |
| valid_o | output | 1 | valid-data flag (data) |
| valid_oe_o | output | 1 | drive enable for valid_o |
| tx_start_o | output | 1 | one-cycle transmit burst start strobe |
| tx_sig_o | output | 2 | signaling bits captured for the next burst |
| loopback_o | output | 1 | loopback select to the modem |
| ins_en_o | output | 1 | registered insert enable |

## Verification
The bench counts edges from each stimulus. A change of `bus_en_i` or of a control input appears one edge later. A frame-sync rise at `fsync_i` reaches `tx_start_o`, `tx_sig_o` and the running-mode receive outputs two edges after it is first sampled. In power-down, a `demod_done_i` pulse reaches `sig_out_o` and `valid_o` at the same edge that samples it. A behavioural model in the bench advances on each rising edge using these delays. It is compared with every output at the falling edge, so each sample falls half a cycle after the edge that made the change. Directed checks add to this: burst counts over runs of frame-sync pulses, holding of the outputs while running, and freezing while the bus is shared.

// File: rtl/sigfe_pkg.sv
package sigfe_pkg;
  localparam int SIG_W = 2;

  typedef struct packed {
    logic             run;
    logic             lpbk_n;
    logic             ins_en;
    logic [SIG_W-1:0] sig;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{run: 1'b0, lpbk_n: 1'b1, ins_en: 1'b0, sig: '0};

  function automatic logic burst_valid(input logic sync_ok, input logic bit_err);
    return sync_ok & ~bit_err;
  endfunction

  function automatic logic arm_now(input logic rise, input logic demod,
                                   input int unsigned cnt, input int unsigned limit);
    return demod | (rise & (cnt == limit - 1));
  endfunction
endpackage

// File: rtl/sigfe_fsync_edge.sv
module sigfe_fsync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fsync_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= fsync_i;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) sync_q[g] <= 1'b0;
          else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sigfe_ctl_latch.sv
module sigfe_ctl_latch
  import sigfe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  ctl_t d_i,
  output ctl_t q_o,
  output logic oe_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_o  <= CTL_RESET;
      oe_o <= 1'b0;
    end else begin
      oe_o <= en_i;
      if (en_i) q_o <= d_i;
    end
  end
endmodule

// File: rtl/sigfe_pwrup_seq.sv
module sigfe_pwrup_seq
  import sigfe_pkg::*;
#(
  parameter int WAIT_EDGES = 3,
  localparam int CNT_W = $clog2(WAIT_EDGES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic             demod_i,
  output logic             armed_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tx_start_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_o    <= 1'b0;
      cnt_o      <= '0;
      tx_start_o <= 1'b0;
    end else begin
      tx_start_o <= rise_i & armed_o & run_i;
      if (!run_i) begin
        armed_o <= 1'b0;
        cnt_o   <= '0;
      end else if (!armed_o) begin
        if (arm_now(rise_i, demod_i, int'(cnt_o), WAIT_EDGES)) begin
          armed_o <= 1'b1;
          cnt_o   <= '0;
        end else if (rise_i) begin
          cnt_o <= cnt_o + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sigfe_rx_hold.sv
module sigfe_rx_hold
  import sigfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             rise_i,
  input  logic             demod_i,
  input  logic             sync_ok_i,
  input  logic             bit_err_i,
  input  logic [SIG_W-1:0] rx_sig_i,
  output logic [SIG_W-1:0] sig_o,
  output logic             valid_o
);
  logic [SIG_W-1:0] pend_sig_q;
  logic             pend_val_q;
  logic             new_val;

  assign new_val = burst_valid(sync_ok_i, bit_err_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_sig_q <= '0;
      pend_val_q <= 1'b0;
      sig_o      <= '0;
      valid_o    <= 1'b0;
    end else begin
      if (demod_i) begin
        pend_sig_q <= rx_sig_i;
        pend_val_q <= new_val;
      end
      if (run_i) begin
        if (rise_i) begin
          sig_o   <= pend_sig_q;
          valid_o <= pend_val_q;
        end
      end else if (demod_i) begin
        sig_o   <= rx_sig_i;
        valid_o <= new_val;
      end
    end
  end
endmodule

// File: rtl/sigfe_top.sv
module sigfe_top
  import sigfe_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WAIT_EDGES  = 3,
  localparam int CNT_W = $clog2(WAIT_EDGES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run_i,
  input  logic       lpbk_n_i,
  input  logic       ins_en_i,
  input  logic [1:0] sig_in_i,
  input  logic       fsync_i,
  input  logic       bus_en_i,
  input  logic       demod_done_i,
  input  logic       sync_ok_i,
  input  logic       bit_err_i,
  input  logic [1:0] rx_sig_i,
  output logic [1:0] sig_out_o,
  output logic       sig_out_oe_o,
  output logic       valid_o,
  output logic       valid_oe_o,
  output logic       tx_start_o,
  output logic [1:0] tx_sig_o,
  output logic       loopback_o,
  output logic       ins_en_o
);
  ctl_t             ctl_d, ctl_q;
  logic             oe_q;
  logic             fs_rise;
  logic             run_w;
  logic             armed_w;
  logic [CNT_W-1:0] wait_cnt;
  logic [SIG_W-1:0] tx_sig_q;

  assign ctl_d = '{run: run_i, lpbk_n: lpbk_n_i, ins_en: ins_en_i, sig: sig_in_i};
  assign run_w = ctl_q.run;

  sigfe_ctl_latch u_latch (
    .clk(clk), .rst_n(rst_n), .en_i(bus_en_i), .d_i(ctl_d), .q_o(ctl_q), .oe_o(oe_q)
  );

  sigfe_fsync_edge #(.STAGES(SYNC_STAGES)) u_fs (
    .clk(clk), .rst_n(rst_n), .fsync_i(fsync_i), .rise_o(fs_rise)
  );

  sigfe_pwrup_seq #(.WAIT_EDGES(WAIT_EDGES)) u_seq (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .rise_i(fs_rise), .demod_i(demod_done_i),
    .armed_o(armed_w), .cnt_o(wait_cnt), .tx_start_o(tx_start_o)
  );

  sigfe_rx_hold u_rx (
    .clk(clk), .rst_n(rst_n), .run_i(run_w), .rise_i(fs_rise), .demod_i(demod_done_i),
    .sync_ok_i(sync_ok_i), .bit_err_i(bit_err_i), .rx_sig_i(rx_sig_i),
    .sig_o(sig_out_o), .valid_o(valid_o)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                tx_sig_q <= '0;
    else if (run_w && fs_rise) tx_sig_q <= ctl_q.sig;

  assign tx_sig_o     = tx_sig_q;
  assign sig_out_oe_o = oe_q;
  assign valid_oe_o   = oe_q;
  assign loopback_o   = run_w & ~ctl_q.lpbk_n;
  assign ins_en_o     = ctl_q.ins_en;
endmodule

// File: rtl/sigfe_chk.sv
module sigfe_chk #(
  parameter int CNT_W = 2,
  parameter int WAIT_EDGES = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en_i,
  input logic             demod_done_i,
  input logic             sync_ok_i,
  input logic             bit_err_i,
  input logic             run_w,
  input logic             fs_rise,
  input logic [CNT_W-1:0] wait_cnt,
  input logic             tx_start_o,
  input logic [1:0]       sig_out_o,
  input logic             valid_o,
  input logic             sig_out_oe_o,
  input logic             loopback_o
);
  AST_FREEZE_WHEN_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en_i |=> $stable(run_w)); // R1
  AST_OE_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en_i |=> sig_out_oe_o); // R2
  AST_FLOAT_FOLLOWS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en_i |=> !sig_out_oe_o); // R2
  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |-> $past(fs_rise)); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start_o |=> !tx_start_o); // R4
  AST_RUN_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && !fs_rise) |=> ($stable(sig_out_o) && $stable(valid_o))); // R5
  AST_DOWN_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_w && demod_done_i) |=> (valid_o == $past(sync_ok_i && !bit_err_i))); // R7
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wait_cnt) < WAIT_EDGES); // R8
  AST_NO_START_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_w |=> !tx_start_o); // R9
  AST_LOOP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    loopback_o |-> run_w); // R10
endmodule

bind sigfe_top sigfe_chk #(.CNT_W(CNT_W), .WAIT_EDGES(WAIT_EDGES)) i_chk (
  .clk(clk), .rst_n(rst_n), .bus_en_i(bus_en_i), .demod_done_i(demod_done_i),
  .sync_ok_i(sync_ok_i), .bit_err_i(bit_err_i), .run_w(run_w), .fs_rise(fs_rise),
  .wait_cnt(wait_cnt), .tx_start_o(tx_start_o), .sig_out_o(sig_out_o),
  .valid_o(valid_o), .sig_out_oe_o(sig_out_oe_o), .loopback_o(loopback_o)
);

// File: tb/test_sigfe_top.sv
module test_sigfe_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_i = 1'b0, lpbk_n_i = 1'b1, ins_en_i = 1'b0, fsync_i = 1'b0, bus_en_i = 1'b0;
  logic demod_done_i = 1'b0, sync_ok_i = 1'b0, bit_err_i = 1'b0;
  logic [1:0] sig_in_i = 2'b00, rx_sig_i = 2'b00;
  logic [1:0] sig_out_o, tx_sig_o;
  logic sig_out_oe_o, valid_o, valid_oe_o, tx_start_o, loopback_o, ins_en_o;

  int total = 0, bad = 0, cyc = 0, starts = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sigfe_top i_sigfe_top (.*);

  // behavioural reference model
  int fs_pipe[3];
  int m_run, m_lbn, m_ins, m_sig, m_oe, m_waits, m_armed, m_pend_s, m_pend_v;
  int m_out_s, m_out_v, m_start, m_txs;

  task automatic model_reset();
    fs_pipe = '{0, 0, 0};
    m_run = 0; m_lbn = 1; m_ins = 0; m_sig = 0; m_oe = 0; m_waits = 0; m_armed = 0;
    m_pend_s = 0; m_pend_v = 0; m_out_s = 0; m_out_v = 0; m_start = 0; m_txs = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int edge_seen, okb;
      edge_seen = (fs_pipe[1] == 1 && fs_pipe[2] == 0) ? 1 : 0;
      okb = (sync_ok_i && !bit_err_i) ? 1 : 0;
      m_start = (edge_seen == 1 && m_armed == 1 && m_run == 1) ? 1 : 0;
      if (m_run == 1 && edge_seen == 1) m_txs = m_sig;
      if (m_run == 0) begin m_waits = 0; m_armed = 0; end
      else if (m_armed == 0) begin
        if (demod_done_i) m_armed = 1;
        else if (edge_seen == 1) begin
          m_waits++;
          if (m_waits >= 3) begin m_armed = 1; m_waits = 0; end
        end
      end
      if (m_run == 1) begin
        if (edge_seen == 1) begin m_out_s = m_pend_s; m_out_v = m_pend_v; end
      end else if (demod_done_i) begin m_out_s = int'(rx_sig_i); m_out_v = okb; end
      if (demod_done_i) begin m_pend_s = int'(rx_sig_i); m_pend_v = okb; end
      m_oe = int'(bus_en_i);
      if (bus_en_i) begin
        m_run = int'(run_i); m_lbn = int'(lpbk_n_i); m_ins = int'(ins_en_i); m_sig = int'(sig_in_i);
      end
      fs_pipe[2] = fs_pipe[1]; fs_pipe[1] = fs_pipe[0]; fs_pipe[0] = int'(fsync_i);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (tx_start_o) starts++;
    if (rst_n && !done) begin
      check("R2 sig oe", int'(sig_out_oe_o), m_oe);
      check("R2 valid oe", int'(valid_oe_o), m_oe);
      check("R5/R6 sig_out", int'(sig_out_o), m_out_s);
      check("R7 valid", int'(valid_o), m_out_v);
      check("R4/R8/R9 tx_start", int'(tx_start_o), m_start);
      check("R3 tx_sig", int'(tx_sig_o), m_txs);
      check("R10 loopback", int'(loopback_o), (m_run == 1 && m_lbn == 0) ? 1 : 0);
      check("R11 ins_en", int'(ins_en_o), m_ins);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fs_pulses(input int n);
    for (int i = 0; i < n; i++) begin
      fsync_i = 1'b1; tick(4); fsync_i = 1'b0; tick(6);
    end
  endtask

  task automatic demod(input logic [1:0] s, input logic ok, input logic err);
    rx_sig_i = s; sync_ok_i = ok; bit_err_i = err; demod_done_i = 1'b1;
    tick(1); demod_done_i = 1'b0;
  endtask

  initial begin
    int t0;
    tick(3);
    check("R2 reset oe", int'(sig_out_oe_o), 0);
    check("R4 reset start", int'(tx_start_o), 0);
    rst_n = 1'b1;
    bus_en_i = 1'b1; tick(2);
    // R6 / R7 powered-down updates
    demod(2'b10, 1'b1, 1'b0);
    check("R6 down sig", int'(sig_out_o), 2);
    check("R7 good burst", int'(valid_o), 1);
    demod(2'b01, 1'b1, 1'b1);
    check("R7 bit error", int'(valid_o), 0);
    demod(2'b11, 1'b0, 1'b0);
    check("R7 bad sync", int'(valid_o), 0);
    // R9 no bursts while down
    t0 = starts; fs_pulses(4);
    check("R9 no start down", starts - t0, 0);
    // R8 power up, loopback R10
    run_i = 1'b1; lpbk_n_i = 1'b0; sig_in_i = 2'b01; tick(2);
    check("R10 loopback on", int'(loopback_o), 1);
    t0 = starts; fs_pulses(5);
    check("R8 starts after three", starts - t0, 2);
    // R4 latency: fsync high sampled at edge k, start after edge k+2
    fsync_i = 1'b1; tick(2);
    check("R4 not yet", int'(tx_start_o), 0);
    tick(1);
    check("R4 start pulse", int'(tx_start_o), 1);
    tick(1);
    check("R4 one cycle", int'(tx_start_o), 0);
    fsync_i = 1'b0; tick(6);
    // R5 held until frame edge
    demod(2'b10, 1'b1, 1'b0); tick(3);
    check("R5 held", int'(sig_out_o), 3);
    fs_pulses(1);
    check("R5 updated", int'(sig_out_o), 2);
    // R9 re-wait then early arm by demod (R8)
    run_i = 1'b0; tick(2); run_i = 1'b1; tick(2);
    fs_pulses(1); demod(2'b00, 1'b1, 1'b0);
    t0 = starts; fs_pulses(2);
    check("R8 early arm", starts - t0, 2);
    // R1 freeze while shared
    bus_en_i = 1'b0; tick(1);
    run_i = 1'b0; lpbk_n_i = 1'b1; ins_en_i = 1'b1; tick(3);
    check("R1 frozen loopback", int'(loopback_o), 1);
    check("R1 frozen ins", int'(ins_en_o), 0);
    check("R2 floated", int'(valid_oe_o), 0);
    bus_en_i = 1'b1; tick(2);
    check("R1 resample ins", int'(ins_en_o), 1);
    // mixed traffic, model compared each cycle
    for (int i = 0; i < 3000; i++) begin
      fsync_i = ((i % 17) < 5);
      demod_done_i = ($urandom % 11) == 0;
      rx_sig_i = 2'($urandom); sync_ok_i = 1'($urandom); bit_err_i = ($urandom % 4) == 0;
      if ((i % 97) == 0) run_i = 1'($urandom);
      if ((i % 53) == 0) bus_en_i = ($urandom % 3) != 0;
      lpbk_n_i = ($urandom % 5) != 0; sig_in_i = 2'($urandom); ins_en_i = 1'($urandom);
      tick(1);
    end
    demod_done_i = 1'b0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule